// File: doc/BRIEF.md
# Powered-Device Sleep and Keep-Alive Controller

This block is the digital control for the low-power states of a powered device on an Ethernet power link. It decides when the power source must be shown a periodic keep-alive load current. On the line this current is the maintain-power-signature (MPS). The block also decides when the DC-DC converter runs, when the synchronous rectifier driver is allowed, and what a status LED shows. The analog sensing, the pulse current sink and the regulators sit outside the block. They talk to it through single-bit flags and requests.

The sleep input is sampled once, at the instant the hotswap switch first turns on, and that sample picks the keep-alive policy. If the input is low, the block runs in automatic mode and asks for keep-alive pulses whenever the load current is below the threshold. If the input is high, automatic pulses are off. In that case, when the `ENHANCED` parameter is clear, pulling the sleep input low forces pulses for as long as it stays low. When `ENHANCED` is set, a falling edge of the sleep input puts the device to sleep and latches the mode input. A rising edge of the wake input brings the device back. All time is counted in ticks of a one-millisecond strobe. Every asynchronous input passes through a two-flop synchroniser.

Top module: `poe_sleep_ctrl`

## Requirements
- R1: When `sleep_n` is low as `hs_start` is seen, automatic mode is chosen. While awake, keep-alive is active exactly while `below_mps` is 1.
- R2: When `sleep_n` is high as `hs_start` is seen, `below_mps` has no effect on `mps_req`. With `ENHANCED`=0, keep-alive is active exactly while `sleep_n` is 0.
- R3: With `ENHANCED`=1, a falling edge of `sleep_n` after start puts the device to sleep, and `dcdc_en` goes to 0.
- R4: The value of `mode` at the sleep edge is held for the whole sleep, and later changes of `mode` have no effect. During sleep, keep-alive is active if and only if the held value is 0.
- R5: A rising edge of `wake` during sleep makes the device awake, and `dcdc_en` returns to 1. A rising edge of `wake` while awake does not change `dcdc_en`. If a `sleep_n` fall and a `wake` rise reach the block in the same cycle while it is awake, sleep is entered.
- R6: `sr_en` is 0 exactly while `low_cur` is 1, and is 1 otherwise.
- R7: While keep-alive is active, `mps_req` is 1 for 75 ticks and then 0 for 225 ticks, repeating. It starts with the high phase when keep-alive becomes active and drops as soon as keep-alive ends.
- R8: `led` is 1 while awake. During sleep it holds 1 for 500 ticks and then 0 for 500 ticks, repeating. With `ENHANCED`=0, `led` and `dcdc_en` stay at 1.
- R9: After reset, and until `hs_start` is seen, `dcdc_en`=1, `sr_en`=1, `led`=1 and `mps_req`=0, whatever `below_mps` and `sleep_n` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond, synchronous |
| hs_start | input | 1 | Strobe at first hotswap switch turn-on |
| sleep_n | input | 1 | Active-low sleep request |
| mode | input | 1 | Keep-alive-in-sleep selector (0 = keep alive) |
| wake | input | 1 | Wake request, rising edge |
| low_cur | input | 1 | Average load current below the low-current limit |
| below_mps | input | 1 | Load current below the keep-alive threshold |
| dcdc_en | output | 1 | DC-DC converter run enable |
| sr_en | output | 1 | Synchronous rectifier driver enable |
| mps_req | output | 1 | Keep-alive pulse current request |
| led | output | 1 | Status LED drive |

## Verification
The sleep falling edge and the wake rising edge can reach the state logic in the same cycle. The bench provokes this by changing `sleep_n` and `wake` at the same clock edge while the device is awake. It then judges the result from `dcdc_en` and the LED after the synchroniser delay: the device must go to sleep. A second overlap is the keep-alive period counter wrapping in the same cycle that its activation condition changes. The bench covers this by measuring exact high and low widths of `mps_req` in ticks, and by checking that `mps_req` drops as soon as `below_mps` clears.

// File: rtl/poe_sleep_ctrl.sv
module poe_sleep_ctrl #(
  parameter bit          ENHANCED      = 1'b1,
  parameter int unsigned MPS_ON_MS     = 75,
  parameter int unsigned MPS_OFF_MS    = 225,
  parameter int unsigned BLINK_HALF_MS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic hs_start,
  input  logic sleep_n,
  input  logic mode,
  input  logic wake,
  input  logic low_cur,
  input  logic below_mps,
  output logic dcdc_en,
  output logic sr_en,
  output logic mps_req,
  output logic led
);
  localparam int unsigned PERIOD = MPS_ON_MS + MPS_OFF_MS;
  localparam int CW = $clog2(PERIOD);
  localparam int BW = $clog2(BLINK_HALF_MS);
  localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] CNT_ON   = CW'(MPS_ON_MS);
  localparam logic [BW-1:0] BLK_LAST = BW'(BLINK_HALF_MS - 1);
  localparam int I_START = 5, I_SLP = 4, I_MODE = 3, I_WAKE = 2, I_LOW = 1, I_BELOW = 0;

  logic [5:0] s1, s2;
  logic prv_start, prv_slp, prv_wake;
  logic armed, auto_q, act_q, asleep, mode_lat, led_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bcnt;

  wire start_rise = s2[I_START] & ~prv_start;
  wire slp_fall   = ~s2[I_SLP] & prv_slp;
  wire wake_rise  = s2[I_WAKE] & ~prv_wake;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0;
      prv_start <= 1'b0; prv_slp <= 1'b0; prv_wake <= 1'b0;
    end else begin
      s1 <= {hs_start, sleep_n, mode, wake, low_cur, below_mps};
      s2 <= s1;
      prv_start <= s2[I_START];
      prv_slp   <= s2[I_SLP];
      prv_wake  <= s2[I_WAKE];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed  <= 1'b0;
      auto_q <= 1'b0;
    end else if (start_rise && !armed) begin
      armed  <= 1'b1;
      auto_q <= ~s2[I_SLP];
    end

  generate
    if (ENHANCED) begin : g_sleep
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          asleep   <= 1'b0;
          mode_lat <= 1'b0;
        end else if (!asleep) begin
          if (armed && slp_fall) begin
            asleep   <= 1'b1;
            mode_lat <= s2[I_MODE];
          end
        end else if (wake_rise) begin
          asleep <= 1'b0;
        end
    end else begin : g_nosleep
      assign asleep   = 1'b0;
      assign mode_lat = 1'b0;
    end
  endgenerate

  wire forced   = !ENHANCED && !auto_q && !s2[I_SLP];
  wire mps_want = armed && (asleep ? !mode_lat : (auto_q ? s2[I_BELOW] : forced));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt   <= '0;
    end else begin
      act_q <= mps_want;
      if (!act_q)       cnt <= '0;
      else if (ms_tick) cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      led_q <= 1'b1;
      bcnt  <= '0;
    end else if (!asleep) begin
      led_q <= 1'b1;
      bcnt  <= '0;
    end else if (ms_tick) begin
      if (bcnt == BLK_LAST) begin
        bcnt  <= '0;
        led_q <= ~led_q;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end

  assign mps_req = act_q && (cnt < CNT_ON);
  assign sr_en   = ~s2[I_LOW];
  assign dcdc_en = ~asleep;
  assign led     = led_q;

  // R7
  pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mps_req) |-> (!act_q || $past(ms_tick)));
  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(slp_fall && armed));
  // R5
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(wake_rise));
  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && $past(asleep)) |-> $stable(mode_lat));
  // R8
  blink_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && $past(asleep) && !$past(ms_tick)) |-> $stable(led_q));
  // R9
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!act_q && !asleep));
endmodule

// File: tb/poe_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module poe_sleep_ctrl_tb_top;
  localparam int TICK = 2;
  localparam int ON = 75, OFF = 225, HALF = 500;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic hs_start = 0, sleep_n = 1, mode = 0, wake = 0, low_cur = 0, below_mps = 0;
  logic e_dcdc, e_sr, e_mps, e_led, b_dcdc, b_sr, b_mps, b_led;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  poe_sleep_ctrl #(.ENHANCED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .hs_start(hs_start), .sleep_n(sleep_n),
    .mode(mode), .wake(wake), .low_cur(low_cur), .below_mps(below_mps),
    .dcdc_en(e_dcdc), .sr_en(e_sr), .mps_req(e_mps), .led(e_led));

  poe_sleep_ctrl #(.ENHANCED(1'b0)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .hs_start(hs_start), .sleep_n(sleep_n),
    .mode(mode), .wake(wake), .low_cur(low_cur), .below_mps(below_mps),
    .dcdc_en(b_dcdc), .sr_en(b_sr), .mps_req(b_mps), .led(b_led));

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      ms_tick = (div == TICK - 1);
      div = (div == TICK - 1) ? 0 : div + 1;
    end
  end

  // {low_cur, below_mps, expected sr_en, expected mps_req}
  localparam logic [3:0] VEC [7] = '{4'b0010, 4'b1000, 4'b1101, 4'b0111,
                                     4'b0010, 4'b1000, 4'b0010};

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic start_pulse;
    hs_start = 1'b1;
    cyc(1);
    hs_start = 1'b0;
    cyc(6);
  endtask

  task automatic wait_lvl(input logic lvl);
    for (int i = 0; i < 4000 && e_mps !== lvl; i++) @(negedge clk);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (e_mps === lvl && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lo, hi;
    do_reset();
    // R9 reset state and no keep-alive before start
    chk("R9 dcdc", e_dcdc, 1'b1);
    chk("R9 sr", e_sr, 1'b1);
    chk("R9 led", e_led, 1'b1);
    chk("R9 mps", e_mps, 1'b0);
    below_mps = 1; sleep_n = 0;
    cyc(8);
    chk("R9 mps pre-start enh", e_mps, 1'b0);
    chk("R9 mps pre-start basic", b_mps, 1'b0);
    below_mps = 0;
    cyc(4);

    // R1 automatic mode, table walk, R6 rectifier enable
    start_pulse();
    for (int v = 0; v < 7; v++) begin
      low_cur = VEC[v][3];
      below_mps = VEC[v][2];
      cyc(6);
      chk("R6 sr_en", e_sr, VEC[v][1]);
      chk("R1 mps enh", e_mps, VEC[v][0]);
      chk("R1 mps basic", b_mps, VEC[v][0]);
    end
    chk("R1 awake dcdc", e_dcdc, 1'b1);

    // R7 pulse widths
    below_mps = 1;
    wait_lvl(1'b1);
    wait_lvl(1'b0);
    run_len(1'b0, lo);
    run_len(1'b1, hi);
    chk("R7 off width", lo == OFF * TICK, 1'b1);
    if (lo != OFF * TICK) $display("  R7 off cycles %0d", lo);
    chk("R7 on width", hi == ON * TICK, 1'b1);
    if (hi != ON * TICK) $display("  R7 on cycles %0d", hi);
    wait_lvl(1'b1);
    cyc(10);
    below_mps = 0;
    cyc(5);
    chk("R7 drop on inactive", e_mps, 1'b0);

    // R2 non-automatic mode
    sleep_n = 1; mode = 0;
    do_reset();
    start_pulse();
    below_mps = 1;
    cyc(8);
    chk("R2 below ignored enh", e_mps, 1'b0);
    chk("R2 below ignored basic", b_mps, 1'b0);

    // R3/R4 sleep entry with mode 0, R2 forced in basic
    sleep_n = 0;
    cyc(6);
    chk("R3 dcdc off", e_dcdc, 1'b0);
    chk("R8 led high at entry", e_led, 1'b1);
    chk("R4 mps in sleep mode0", e_mps, 1'b1);
    chk("R2 forced basic", b_mps, 1'b1);
    chk("R8 basic dcdc", b_dcdc, 1'b1);
    mode = 1;
    cyc(8);
    chk("R4 mode change ignored", e_mps, 1'b1);
    cyc(HALF * TICK + 4);
    chk("R8 led low", e_led, 1'b0);
    chk("R8 basic led", b_led, 1'b1);
    cyc(HALF * TICK);
    chk("R8 led high again", e_led, 1'b1);

    sleep_n = 1;
    cyc(6);
    chk("R2 forced release basic", b_mps, 1'b0);
    chk("R3 still asleep", e_dcdc, 1'b0);

    // R5 wake
    wake = 1;
    cyc(6);
    chk("R5 awake", e_dcdc, 1'b1);
    chk("R5 led solid", e_led, 1'b1);
    chk("R5 mps off awake", e_mps, 1'b0);
    wake = 0;
    cyc(4);
    wake = 1;
    cyc(6);
    chk("R5 wake while awake", e_dcdc, 1'b1);
    wake = 0;
    cyc(4);

    // R5 same-cycle sleep fall and wake rise
    sleep_n = 0; wake = 1;
    cyc(6);
    chk("R5 simultaneous enters sleep", e_dcdc, 1'b0);
    chk("R4 mode1 latched no mps", e_mps, 1'b0);
    wake = 0;
    cyc(4);
    wake = 1;
    cyc(6);
    chk("R5 second wake", e_dcdc, 1'b1);
    wake = 0; sleep_n = 1;
    cyc(4);

    // R4 sleep with mode 1 then mode 0 change
    sleep_n = 0;
    cyc(6);
    chk("R4 mode1 sleep mps", e_mps, 1'b0);
    mode = 0;
    cyc(8);
    chk("R4 mode1 held", e_mps, 1'b0);
    chk("R6 sr default", e_sr, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule